// File: doc/BRIEF.md
# Transmit Read Burst Aligner

This block decides where a transmit DMA read burst ends. A bus master fetching transmit data into a FIFO reports each dword it receives, together with that dword's address. The block watches two reasons to stop a burst. The first is the transmit FIFO nearing full. The second is a per-burst byte budget that has run out while another DMA channel waits. For each beat it returns a terminate strobe, and a channel-switch strobe when the stop is for arbitration.

With alignment turned off, a stop reason ends the burst on the beat where it appears. With alignment turned on, the stop is held back until the dword that closes the current cache line. The next burst therefore starts on a line-aligned address, which cache-line-oriented memory systems favour. The line is 8 or 16 dwords, chosen by an input. A burst that the bus ends for its own reasons is reported through an abort input. The abort drops any stop that was still waiting.

Top module: `txReadAligner`

## Requirements
- R1: Out of reset, and while no burst is open, `burstTerm` and `switchChan` stay low, even when `beatValid` pulses.
- R2: When `alignEn` is 0, a beat that arrives with `fifoAlmostFull` high raises `burstTerm` in that same cycle.
- R3: When `alignEn` is 1, a stop reason seen on any beat raises `burstTerm` on the first beat, from that one onward, that carries the last dword of a cache line. This holds even if the reason has gone away by then. `burstTerm` is never raised on a beat that does not close a line.
- R4: A beat closes a line when the low 3 bits of `beatAddr` are all ones (`lineSel` = 0, 8-dword lines) or the low 4 bits are all ones (`lineSel` = 1, 16-dword lines).
- R5: The byte count restarts at 0 on `burstStart` and grows by 4 per beat. The budget counts as spent on the beat where the count including that beat is at least `maxBytes`. A `maxBytes` of 0 means no budget.
- R6: `switchChan` rises together with `burstTerm` when the budget is spent while `otherPending` is high. This happens immediately when `alignEn` is 0 and at the line-closing beat when `alignEn` is 1. A spent budget with no other channel pending causes no stop.
- R7: Each strobe lasts one cycle and closes the burst. Later beats cause no strobe until the next `burstStart`.
- R8: `burstAbort` closes the burst and drops any waiting stop. No strobe follows until a new burst, and the new burst does not inherit the stop.
- R9: When alignment is on and a stop reason first appears on a line-closing beat, `burstTerm` rises on that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| alignEn | input | 1 | 1 = hold stops until the end of a cache line |
| lineSel | input | 1 | Cache line size: 0 = 8 dwords, 1 = 16 dwords |
| burstStart | input | 1 | Opens a new burst (no beat in this cycle) |
| beatValid | input | 1 | A dword is delivered this cycle |
| beatAddr | input | ADDR_W | Dword address of the delivered dword |
| fifoAlmostFull | input | 1 | Transmit FIFO nearly out of space |
| maxBytes | input | CNT_W | Byte budget per burst, 0 = none |
| otherPending | input | 1 | Another DMA channel is waiting |
| burstAbort | input | 1 | Burst ended externally this cycle |
| burstTerm | output | 1 | Make this beat the last of the burst |
| switchChan | output | 1 | Hand the bus to the waiting channel after this beat |

## Verification
Most internal faults in this block surface within one cache line. A waiting stop that was lost shows up as a missing `burstTerm` on the next line-closing beat, at most 15 beats after the cause. A stale or inherited stop shows up as an early strobe at the first line end of the following burst. Byte-count errors move the spent-budget beat, which is visible directly in the unaligned mode and at the next line end in the aligned mode. The scoreboard predicts each beat's two strobes from the address, the FIFO flag and the budget. Any shift of even one beat is caught.

// File: rtl/txra_pkg.sv
package txra_pkg;
  typedef struct packed {
    logic clrCount;
    logic incCount;
  } ctlStrobes_t;

  typedef struct packed {
    logic lineEnd;
    logic limitHit;
  } dpFlags_t;
endpackage

// File: rtl/txra_datapath.sv
module txra_datapath
  import txra_pkg::*;
#(
  parameter int ADDR_W     = 30,
  parameter int CNT_W      = 16,
  parameter int SHORT_LINE = 8,
  parameter int LONG_LINE  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lineSel,
  input  logic [ADDR_W-1:0] beatAddr,
  input  logic [CNT_W-1:0]  maxBytes,
  input  ctlStrobes_t       strobes,
  output dpFlags_t          flags
);
  localparam int SHORT_BITS = $clog2(SHORT_LINE);
  localparam int LONG_BITS  = $clog2(LONG_LINE);
  localparam int WIDE_W     = CNT_W + 1;

  logic [WIDE_W-1:0] byteCount;
  logic [WIDE_W-1:0] bytesNow;
  logic              shortEnd;
  logic              longEnd;

  assign shortEnd = &beatAddr[SHORT_BITS-1:0];
  assign longEnd  = &beatAddr[LONG_BITS-1:0];

  always_comb begin
    bytesNow       = byteCount + WIDE_W'(4);
    flags.lineEnd  = lineSel ? longEnd : shortEnd;
    flags.limitHit = (maxBytes != '0) && (bytesNow >= {1'b0, maxBytes});
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clrCount) begin
      byteCount <= '0;
    end else if (strobes.incCount && !byteCount[WIDE_W-1]) begin
      byteCount <= bytesNow;
    end
  end

  a_r5_count_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clrCount |=> byteCount == '0);

  a_r5_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.incCount && !strobes.clrCount && !byteCount[WIDE_W-1])
      |=> byteCount == $past(byteCount) + WIDE_W'(4));
endmodule

// File: rtl/txra_control.sv
module txra_control
  import txra_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        alignEn,
  input  logic        burstStart,
  input  logic        beatValid,
  input  logic        fifoAlmostFull,
  input  logic        otherPending,
  input  logic        burstAbort,
  input  dpFlags_t    flags,
  output ctlStrobes_t strobes,
  output logic        burstTerm,
  output logic        switchChan
);
  logic active;
  logic pendTerm;
  logic pendSwitch;
  logic beatLive;
  logic arbCause;
  logic anyCause;
  logic termNow;
  logic swNow;

  always_comb begin
    beatLive = active && beatValid && !burstAbort && !burstStart;
    arbCause = flags.limitHit && otherPending;
    anyCause = fifoAlmostFull || arbCause;
    if (alignEn) begin
      termNow = beatLive && flags.lineEnd && (pendTerm || anyCause);
      swNow   = beatLive && flags.lineEnd && (pendSwitch || arbCause);
    end else begin
      termNow = beatLive && (pendTerm || anyCause);
      swNow   = beatLive && (pendSwitch || arbCause);
    end
    strobes.clrCount = burstStart;
    strobes.incCount = beatLive;
  end

  assign burstTerm  = termNow;
  assign switchChan = swNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active     <= 1'b0;
      pendTerm   <= 1'b0;
      pendSwitch <= 1'b0;
    end else if (burstStart) begin
      active     <= 1'b1;
      pendTerm   <= 1'b0;
      pendSwitch <= 1'b0;
    end else if (burstAbort || termNow) begin
      active     <= 1'b0;
      pendTerm   <= 1'b0;
      pendSwitch <= 1'b0;
    end else if (beatLive && alignEn) begin
      pendTerm   <= pendTerm | anyCause;
      pendSwitch <= pendSwitch | arbCause;
    end
  end

  a_r3_term_on_line_end: assert property (@(posedge clk) disable iff (!rstN)
    (alignEn && burstTerm) |-> flags.lineEnd);

  a_r2_immediate_stop: assert property (@(posedge clk) disable iff (!rstN)
    (!alignEn && beatLive && fifoAlmostFull) |-> burstTerm);

  a_r6_switch_with_term: assert property (@(posedge clk) disable iff (!rstN)
    switchChan |-> burstTerm);

  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    burstTerm |=> !burstTerm);

  a_r8_abort_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (burstAbort && !burstStart) |=> !burstTerm);
endmodule

// File: rtl/txReadAligner.sv
module txReadAligner
  import txra_pkg::*;
#(
  parameter int ADDR_W     = 30,
  parameter int CNT_W      = 16,
  parameter int SHORT_LINE = 8,
  parameter int LONG_LINE  = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              alignEn,
  input  logic              lineSel,
  input  logic              burstStart,
  input  logic              beatValid,
  input  logic [ADDR_W-1:0] beatAddr,
  input  logic              fifoAlmostFull,
  input  logic [CNT_W-1:0]  maxBytes,
  input  logic              otherPending,
  input  logic              burstAbort,
  output logic              burstTerm,
  output logic              switchChan
);
  ctlStrobes_t strobes;
  dpFlags_t    flags;

  txra_datapath #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W),
    .SHORT_LINE(SHORT_LINE), .LONG_LINE(LONG_LINE)
  ) uDp (
    .clk(clk), .rstN(rstN), .lineSel(lineSel), .beatAddr(beatAddr),
    .maxBytes(maxBytes), .strobes(strobes), .flags(flags)
  );

  txra_control uCtl (
    .clk(clk), .rstN(rstN), .alignEn(alignEn), .burstStart(burstStart),
    .beatValid(beatValid), .fifoAlmostFull(fifoAlmostFull),
    .otherPending(otherPending), .burstAbort(burstAbort), .flags(flags),
    .strobes(strobes), .burstTerm(burstTerm), .switchChan(switchChan)
  );
endmodule

// File: tb/sim_txReadAligner.sv
module sim_txReadAligner;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        alignEn = 1'b0, lineSel = 1'b0, burstStart = 1'b0, beatValid = 1'b0;
  logic [29:0] beatAddr = '0;
  logic        fifoAlmostFull = 1'b0, otherPending = 1'b0, burstAbort = 1'b0;
  logic [15:0] maxBytes = '0;
  logic        burstTerm, switchChan;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  typedef struct {
    logic  t;
    logic  s;
    string tag;
  } exp_t;
  exp_t q[$];

  always #10 clk = ~clk;

  txReadAligner u0 (
    .clk(clk), .rstN(rstN), .alignEn(alignEn), .lineSel(lineSel),
    .burstStart(burstStart), .beatValid(beatValid), .beatAddr(beatAddr),
    .fifoAlmostFull(fifoAlmostFull), .maxBytes(maxBytes),
    .otherPending(otherPending), .burstAbort(burstAbort),
    .burstTerm(burstTerm), .switchChan(switchChan)
  );

  // monitor: compares each beat against the scoreboard queue
  always @(negedge clk) begin
    if (rstN) begin
      if (beatValid) begin
        total++;
        if (q.size() == 0) begin
          bad++;
          $display("FAIL %s: unexpected beat, actual term=%0b sw=%0b expected none", "R7", burstTerm, switchChan);
        end else begin
          exp_t e;
          e = q.pop_front();
          if (burstTerm !== e.t || switchChan !== e.s) begin
            bad++;
            $display("FAIL %s: addr=%0d actual term=%0b sw=%0b expected term=%0b sw=%0b",
                     e.tag, beatAddr, burstTerm, switchChan, e.t, e.s);
          end
        end
      end else if (burstTerm || switchChan) begin
        total++;
        bad++;
        $display("FAIL R7: strobe without beat, actual term=%0b sw=%0b expected 0 0", burstTerm, switchChan);
      end
    end
  end

  task automatic stepIdle();
    @(posedge clk); #1;
    burstStart = 0; beatValid = 0; burstAbort = 0; fifoAlmostFull = 0;
  endtask

  // Driver: opens a burst, drives n beats, pushes the modelled strobes.
  task automatic runBurst(input string tag, input logic [29:0] start, input int n,
                          input bit en, input bit sel, input int afFrom, input int afTo,
                          input int mb, input bit op, input int abortAt, input bit open);
    bit act = open;
    bit pT = 0, pS = 0;
    int bytes = 0;
    alignEn = en; lineSel = sel; maxBytes = 16'(mb); otherPending = op;
    if (open) begin
      @(posedge clk); #1;
      burstStart = 1; beatValid = 0; burstAbort = 0; fifoAlmostFull = 0;
    end
    for (int i = 0; i < n; i++) begin
      logic [29:0] a;
      bit le, af, arb, cause, t, s, ab;
      exp_t e;
      a  = start + 30'(i);
      le = sel ? (a[3:0] == 4'hF) : (a[2:0] == 3'h7);
      af = (i >= afFrom) && (i <= afTo);
      ab = (i == abortAt);
      t = 0; s = 0;
      if (act && !ab) begin
        bytes += 4;
        arb   = (mb != 0) && (bytes >= mb) && op;
        cause = af || arb;
        if (en) begin
          t = le && (pT || cause);
          s = le && (pS || arb);
        end else begin
          t = pT || cause;
          s = pS || arb;
        end
        if (t) begin act = 0; pT = 0; pS = 0; end
        else if (en) begin pT = pT | cause; pS = pS | arb; end
      end else if (ab) begin
        act = 0; pT = 0; pS = 0;
      end
      e.t = t; e.s = s; e.tag = tag;
      @(posedge clk); #1;
      q.push_back(e);
      burstStart = 0; beatValid = 1; beatAddr = a; fifoAlmostFull = af; burstAbort = ab;
    end
    stepIdle();
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    total++;
    if (burstTerm !== 0 || switchChan !== 0) begin
      bad++;
      $display("FAIL R1: actual term=%0b sw=%0b expected 0 0", burstTerm, switchChan);
    end
    rstN = 1;
    // R1: beats with no open burst
    runBurst("R1", 30'd0, 10, 0, 0, 0, 9, 4, 1, -1, 0);
    // R2 + R7: immediate stop, later beats silent
    runBurst("R2", 30'd0, 6, 0, 0, 2, 2, 0, 0, -1, 1);
    // R3: pulse of almost-full held until line end (8 dwords)
    runBurst("R3", 30'd0, 12, 1, 0, 2, 2, 0, 0, -1, 1);
    // R4: 16-dword lines
    runBurst("R4", 30'd0, 20, 1, 1, 3, 3, 0, 0, -1, 1);
    // R4: unaligned start address
    runBurst("R4", 30'd5, 8, 1, 0, 0, 0, 0, 0, -1, 1);
    // R5/R6: budget of 12 bytes, unaligned -> switch on 3rd beat
    runBurst("R6", 30'd0, 6, 0, 0, -1, -1, 12, 1, -1, 1);
    // R6: aligned switch at line end
    runBurst("R6", 30'd0, 12, 1, 0, -1, -1, 8, 1, -1, 1);
    // R5: zero budget means none
    runBurst("R5", 30'd0, 20, 1, 0, -1, -1, 0, 1, -1, 1);
    // R6: spent budget but no other channel pending
    runBurst("R6", 30'd0, 20, 0, 0, -1, -1, 8, 0, -1, 1);
    // R5: budget reached exactly at 40 bytes, 16-dword aligned
    runBurst("R5", 30'd0, 20, 1, 1, -1, -1, 40, 1, -1, 1);
    // R9: cause first seen on a line-closing beat
    runBurst("R9", 30'd0, 10, 1, 0, 7, 7, 0, 0, -1, 1);
    // R8: abort drops waiting stop, then a fresh burst inherits nothing
    runBurst("R8", 30'd0, 12, 1, 0, 2, 2, 0, 0, 4, 1);
    runBurst("R8", 30'd0, 12, 1, 0, -1, -1, 0, 0, -1, 1);
    repeat (3) stepIdle();
    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R7: leftover expected items actual=%0d expected=0", q.size());
    end
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule